// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a small data cache placed between a load/store unit and a slower word-addressed backing memory. It stores 64-bit words in lines of 16 bytes, so each line holds two words. The line count is a parameter and does not have to be a power of two. The block number is the byte address divided by 16. The line a block maps to is the block number modulo the line count. The tag kept beside the line is the block number divided by the line count. Together, tag and line position identify the block exactly.

Loads that hit are answered from the cache without any memory traffic. A load miss fetches the whole line, installs it and returns the requested word. Every store is sent to memory as a single-word write. A store that hits also patches the cached copy. A store that misses leaves the cache untouched.

The controller handles one request at a time and moves through five named states. IDLE accepts a request. LOOKUP compares the tag. FILL waits for a line read. WRMEM waits for a word write. DONE presents the response.

The transitions are:
- IDLE to LOOKUP when a request is accepted.
- LOOKUP to DONE on a load hit.
- LOOKUP to FILL on a load miss.
- LOOKUP to WRMEM on any store.
- FILL to DONE when the memory acknowledges.
- WRMEM to DONE when the memory acknowledges.
- DONE back to IDLE unconditionally.

Top module: `dcache_wt`

## Requirements
- R1: After reset all lines are invalid, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first access to any address reports a miss.
- R2: A byte address maps to line (addr/16) mod NUM_LINES with tag (addr/16)/NUM_LINES. Two blocks whose numbers differ by NUM_LINES share a line and evict each other.
- R3: A load that hits returns the cached word with `rsp_hit`=1 and issues no memory request.
- R4: A load miss issues one line read (`mem_we`=0) at the address with its low 4 bits cleared. `mem_rline[63:0]` is the word at the lower address (address bit 3 = 0) and `mem_rline[127:64]` is the word with bit 3 = 1. The line is installed, and the word picked by request address bit 3 is returned with `rsp_hit`=0.
- R5: Every store issues exactly one word write (`mem_we`=1) carrying the request address with bits 2:0 cleared and the store data, whether it hits or misses.
- R6: A store miss reads no line and changes no line: the block previously resident in that line still hits afterwards, and the stored block still misses.
- R7: A store hit updates the cached word, so a later load of that address hits and returns the stored value.
- R8: Each accepted request produces `rsp_valid` for exactly one cycle. `req_ready` is 0 from acceptance until after that response.
- R9: Once raised, `mem_req` stays high, with address, direction and data unchanged, until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address, 8-byte aligned |
| req_wdata | input | 64 | Store data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 64 | Load data |
| rsp_hit | output | 1 | 1 = request hit the cache |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | ADDR_W | Byte address of line or word |
| mem_wdata | output | 64 | Word write data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rline | input | 128 | Line read data |

## Verification
The hardest case to reach from the ports is a store miss aimed at a line that already holds a different valid block. Only that situation shows whether no-allocate really keeps the old tag, data and valid bit. The directed stimulus therefore first loads block 0. It then stores to block 3, which shares the line in the three-line configuration, and immediately loads block 0 again, expecting a hit with unchanged data. After that it loads block 3, expecting a miss. Random traffic then confines addresses to sixteen blocks with random memory latency, so the modulo collisions and store-hit patching recur many times against a bench model of tags and memory.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

    localparam int LINE_WORDS = 2;
    localparam int WORD_W     = 64;
    localparam int LINE_W     = LINE_WORDS * WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_WRMEM,
        ST_DONE
    } dc_state_e;

endpackage

// File: rtl/dcache_addr_split.sv
module dcache_addr_split #(
    parameter int ADDR_W    = 16,
    parameter int NUM_LINES = 3,
    localparam int BLK_W    = ADDR_W - 4,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [BLK_W-1:0]  tag,
    output logic              wsel
);
    localparam logic [BLK_W-1:0] NL_B = BLK_W'(NUM_LINES);

    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] rem;

    always_comb begin
        blk  = addr[ADDR_W-1:4];
        rem  = blk % NL_B;
        idx  = rem[IDX_W-1:0];
        tag  = blk / NL_B;
        wsel = addr[3];
    end
endmodule

// File: rtl/dcache_store.sv
module dcache_store #(
    parameter int ADDR_W    = 16,
    parameter int NUM_LINES = 3,
    localparam int TAG_W    = ADDR_W - 4,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int WORD_W   = dcache_pkg::WORD_W,
    localparam int LINE_W   = dcache_pkg::LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              wsel,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              word_en,
    input  logic [WORD_W-1:0] word_data,
    output logic              look_hit,
    output logic [WORD_W-1:0] look_word
);
    logic [NUM_LINES-1:0]                 vld_all;
    logic [NUM_LINES-1:0][TAG_W-1:0]      tag_all;
    logic [NUM_LINES-1:0][LINE_W-1:0]     dat_all;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic              vld_q;
        logic [TAG_W-1:0]  tag_q;
        logic [WORD_W-1:0] w0_q;
        logic [WORD_W-1:0] w1_q;
        logic              sel_me;

        assign sel_me = (idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (fill_en && sel_me) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && sel_me) begin
                tag_q <= tag;
                w0_q  <= fill_line[WORD_W-1:0];
                w1_q  <= fill_line[LINE_W-1:WORD_W];
            end else if (word_en && sel_me) begin
                if (wsel) begin
                    w1_q <= word_data;
                end else begin
                    w0_q <= word_data;
                end
            end
        end

        assign vld_all[g] = vld_q;
        assign tag_all[g] = tag_q;
        assign dat_all[g] = {w1_q, w0_q};
    end

    always_comb begin
        look_hit  = 1'b0;
        look_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (idx == IDX_W'(i)) begin
                look_hit  = vld_all[i] && (tag_all[i] == tag);
                look_word = wsel ? dat_all[i][LINE_W-1:WORD_W]
                                 : dat_all[i][WORD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rline,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [WORD_W-1:0] cur_wdata,
    input  logic              look_hit,
    input  logic [WORD_W-1:0] look_word,
    output logic              fill_en,
    output logic              word_en
);
    dc_state_e state, nxt;

    logic              r_write;
    logic [ADDR_W-1:0] r_addr;
    logic [WORD_W-1:0] r_wdata;
    logic [WORD_W-1:0] rdata_q;
    logic              hit_q;
    logic              accept;

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = ST_LOOKUP;
            ST_LOOKUP: begin
                if (r_write)       nxt = ST_WRMEM;
                else if (look_hit) nxt = ST_DONE;
                else               nxt = ST_FILL;
            end
            ST_FILL:   if (mem_ack) nxt = ST_DONE;
            ST_WRMEM:  if (mem_ack) nxt = ST_DONE;
            ST_DONE:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_DONE);
        mem_req   = (state == ST_FILL) || (state == ST_WRMEM);
        mem_we    = (state == ST_WRMEM);
        mem_addr  = (state == ST_FILL) ? {r_addr[ADDR_W-1:4], 4'b0000}
                                       : {r_addr[ADDR_W-1:3], 3'b000};
        mem_wdata = r_wdata;
        fill_en   = (state == ST_FILL) && mem_ack;
        word_en   = (state == ST_LOOKUP) && r_write && look_hit;
        rsp_rdata = rdata_q;
        rsp_hit   = hit_q;
        cur_addr  = r_addr;
        cur_wdata = r_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            rdata_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (accept) begin
                r_write <= req_write;
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
            end
            if (state == ST_LOOKUP) begin
                hit_q <= look_hit;
                if (!r_write && look_hit) begin
                    rdata_q <= look_word;
                end
            end
            if (fill_en) begin
                rdata_q <= r_addr[3] ? mem_rline[LINE_W-1:WORD_W]
                                     : mem_rline[WORD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
    parameter int ADDR_W    = 16,
    parameter int NUM_LINES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [127:0]      mem_rline
);
    localparam int TAG_W = ADDR_W - 4;
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [ADDR_W-1:0] cur_addr;
    logic [63:0]       cur_wdata;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              wsel;
    logic              look_hit;
    logic [63:0]       look_word;
    logic              fill_en;
    logic              word_en;

    dcache_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_hit   (rsp_hit),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rline (mem_rline),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .look_hit  (look_hit),
        .look_word (look_word),
        .fill_en   (fill_en),
        .word_en   (word_en)
    );

    dcache_addr_split #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_split (
        .addr (cur_addr),
        .idx  (idx),
        .tag  (tag),
        .wsel (wsel)
    );

    dcache_store #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .tag       (tag),
        .wsel      (wsel),
        .fill_en   (fill_en),
        .fill_line (mem_rline),
        .word_en   (word_en),
        .word_data (cur_wdata),
        .look_hit  (look_hit),
        .look_word (look_word)
    );
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [63:0]       mem_wdata,
    input logic              mem_ack
);
    a_r8_one_cycle_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_no_ready_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_addr[3:0] == 4'b0000));

    a_r5_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr[2:0] == 3'b000));

    a_r8_idle_during_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
endmodule

bind dcache_wt dcache_wt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/dcache_wt_test.sv
module dcache_wt_test;
    localparam int AW = 16;
    localparam int NL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic          rsp_hit;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic          mem_ack = 1'b0;
    logic [127:0]  mem_rline = '0;

    int total = 0;
    int bad = 0;
    int n_reads = 0;
    int n_writes = 0;
    int glitches = 0;
    logic [AW-1:0] last_waddr;
    logic [63:0]   bmem [64];
    logic          m_valid [NL];
    int            m_tag [NL];
    bit            finished = 0;

    always #2.5 clk = ~clk;

    dcache_wt #(.ADDR_W(AW), .NUM_LINES(NL)) uut (.*);

    function automatic int f_idx(input int a);
        return (a / 16) % NL;
    endfunction

    function automatic int f_tag(input int a);
        return (a / 16) / NL;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // memory responder with random latency
    initial begin
        int wait_cnt = 0;
        bit pend = 0;
        logic [AW-1:0] p_addr = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (!pend) begin
                    pend = 1;
                    p_addr = mem_addr;
                end else if (mem_addr != p_addr) begin
                    glitches++;
                end
                if (wait_cnt == 0) begin
                    mem_ack = 1'b1;
                    pend = 0;
                    if (mem_we) begin
                        bmem[mem_addr[8:3]] = mem_wdata;
                        last_waddr = mem_addr;
                        n_writes++;
                    end else begin
                        mem_rline = {bmem[{mem_addr[8:4], 1'b1}], bmem[{mem_addr[8:4], 1'b0}]};
                        n_reads++;
                    end
                    wait_cnt = int'($urandom % 3);
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic do_op(input bit wr, input int a, input logic [63:0] d);
        bit            exp_hit;
        int            r0;
        int            w0;
        logic [63:0]   exp_data;
        int            guard = 0;
        exp_hit  = m_valid[f_idx(a)] && (m_tag[f_idx(a)] == f_tag(a));
        exp_data = bmem[a / 8];
        r0 = n_reads;
        w0 = n_writes;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(a);
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk(rsp_valid, "R8 response", 64'(rsp_valid), 64'd1);
        chk(rsp_hit == exp_hit, exp_hit ? "R3 hit flag" : "R2 miss flag",
            64'(rsp_hit), 64'(exp_hit));
        if (!wr) begin
            chk(rsp_rdata == exp_data, exp_hit ? "R3 load data" : "R4 load data",
                rsp_rdata, exp_data);
            chk((n_reads - r0) == (exp_hit ? 0 : 1), "R4 line reads",
                64'(n_reads - r0), exp_hit ? 64'd0 : 64'd1);
            if (!exp_hit) begin
                m_valid[f_idx(a)] = 1'b1;
                m_tag[f_idx(a)]   = f_tag(a);
            end
        end else begin
            chk((n_writes - w0) == 1, "R5 word write count", 64'(n_writes - w0), 64'd1);
            chk(last_waddr == AW'(a), "R5 write address", 64'(last_waddr), 64'(a));
            chk(bmem[a / 8] == d, "R5 write data", bmem[a / 8], d);
            chk(n_reads == r0, "R6 no line read on store", 64'(n_reads - r0), 64'd0);
        end
        @(negedge clk);
        chk(!rsp_valid, "R8 single pulse", 64'(rsp_valid), 64'd0);
        chk(req_ready, "R8 ready after response", 64'(req_ready), 64'd1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) bmem[i] = {$urandom, $urandom};
        for (int i = 0; i < NL; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = 0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1 no response in reset", 64'(rsp_valid), 64'd0);
        chk(mem_req == 1'b0, "R1 no memory request", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: first access misses; R4: line fill, then other word hits
        do_op(0, 0, 64'd0);
        do_op(0, 8, 64'd0);
        // R2: block 3 shares line 0 with block 0
        do_op(0, 48, 64'd0);
        do_op(0, 0, 64'd0);
        // R6: store miss to block 3 keeps block 0 resident
        do_op(1, 56, 64'h1111_2222_3333_4444);
        do_op(0, 0, 64'd0);
        do_op(0, 56, 64'd0);
        // R6: store miss to a cold line leaves it invalid
        do_op(1, 16, 64'hdead_beef_0000_0001);
        do_op(0, 16, 64'd0);
        // R7: store hit patches the line, later load returns new value
        do_op(1, 24, 64'hcafe_f00d_5555_aaaa);
        do_op(0, 24, 64'd0);
        do_op(0, 16, 64'd0);

        for (int k = 0; k < 400; k++) begin
            do_op(($urandom % 10) < 4, int'(($urandom % 32) * 8), {$urandom, $urandom});
        end

        chk(glitches == 0, "R9 address held until ack", 64'(glitches), 64'd0);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end
endmodule